// File: doc/BRIEF.md
# Systolic GF(2^8) FIR Filter

This block is a streaming finite-impulse-response filter whose arithmetic lives in the Galois field GF(2^8). Each tap multiplies a byte sample by a fixed byte coefficient as a carry-less polynomial product, reduced modulo a parameterised degree-8 polynomial. The tap products are combined with bitwise XOR. The coefficients are chosen offline from a windowed design and are fixed at elaboration through a packed parameter. The filter order is a parameter, and orders 7, 8 and 11 (8, 9 and 12 taps) are supported.

The structure is a systolic array. Each cell holds its own coefficient. Every accepted sample is broadcast to all cells at once, and partial results advance one cell per accepted sample through a register in each cell. The coefficients sit in the cells in reverse order, so the value leaving the last cell is y[n] = XOR over k of h[k]·x[n-k]. Samples enter on a valid/ready stream and results leave on a second valid/ready stream. The whole array advances only when a sample is accepted, so gaps in the input and back-pressure on the output never corrupt the history.

Handshake rules: a sample transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its value and no sample is accepted.

Top module: `gf_systolic_fir`

## Requirements
- R1: After reset, the n-th result equals XOR over k of gf(h[k], x[n-k]) for accepted samples x. Here gf is the carry-less product reduced modulo POLY (default 0x11B), and h[k] is byte k of H_PACK (bits 8k+7..8k).
- R2: Tap products are combined with XOR. A single accepted 0x01 followed by accepted 0x00 samples yields h[0], h[1], …, h[N-1] and then 0x00.
- R3: A synchronous reset clears the history, so results after reset treat every earlier sample as zero.
- R4: A result is due one cycle after its sample is accepted: `out_valid` is high on the next cycle, and `out_data` carries that sample's result.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` is unchanged.
- R6: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A sample offered while `in_ready` is low is not consumed and leaves later results unchanged.
- R7: Cycles with `in_valid` low do not advance the history. Gaps between samples insert no zeros.
- R8: When a result is consumed and no new sample is accepted in the same cycle, `out_valid` is low on the next cycle.
- R9: During and right after reset, `out_valid` is low and `out_data` is 0x00.
- R10: Orders 7, 8 and 11 each give the R1 result over their own 8, 9 or 12 taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Filter can take a sample |
| in_data | input | 8 | Input sample byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 8 | Filter result byte |

## Verification
Every result is due on the cycle right after the edge that accepted its sample. That result then stays on the output until the edge where `out_ready` takes it. The bench keeps a reference history that advances only on the edges where it predicts an acceptance. It compares `in_ready`, `out_valid` and `out_data` at the falling edge that follows each rising edge, before the next rising edge can move them. Three filters of order 7, 8 and 11 run on the same stimulus, and each is checked against its own expected value.

// File: rtl/gf8_pkg.sv
package gf8_pkg;
  typedef logic [7:0] gf_byte_t;

  localparam int MAX_TAPS = 12;

  // Carry-less product of a and b, reduced by poly (bit 8 implied set).
  // Horner form: walk b from its top bit, doubling the accumulator in the field.
  function automatic gf_byte_t gf8_mul(input gf_byte_t a, input gf_byte_t b,
                                       input logic [8:0] poly);
    gf_byte_t acc;
    acc = '0;
    for (int i = 7; i >= 0; i--) begin
      acc = {acc[6:0], 1'b0} ^ (acc[7] ? poly[7:0] : 8'h00);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction
endpackage

// File: rtl/gf8_mult.sv
module gf8_mult
  import gf8_pkg::*;
#(
  parameter logic [8:0] POLY = 9'h11B
) (
  input  gf_byte_t a,
  input  gf_byte_t b,
  output gf_byte_t p
);
  always_comb p = gf8_mul(a, b, POLY);
endmodule

// File: rtl/gf_fir_cell.sv
module gf_fir_cell
  import gf8_pkg::*;
#(
  parameter logic [7:0] COEF = 8'h01,
  parameter logic [8:0] POLY = 9'h11B
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  gf_byte_t x_bcast,
  input  gf_byte_t part_in,
  output gf_byte_t part_out
);
  gf_byte_t prod;

  gf8_mult #(.POLY(POLY)) mul_i (
    .a(COEF),
    .b(x_bcast),
    .p(prod)
  );

  always_ff @(posedge clk) begin
    if (rst)       part_out <= '0;
    else if (step) part_out <= part_in ^ prod;
  end
endmodule

// File: rtl/gf_fir_flow.sv
module gf_fir_flow (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic step,
  output logic out_valid
);
  always_comb begin
    in_ready = !out_valid || out_ready;
    step     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (step)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end
endmodule

// File: rtl/gf_systolic_fir.sv
module gf_systolic_fir
  import gf8_pkg::*;
#(
  parameter int                    ORDER  = 7,
  parameter logic [8:0]            POLY   = 9'h11B,
  parameter logic [8*MAX_TAPS-1:0] H_PACK = 96'h03_07_12_2C_4E_63_63_4E_2C_12_07_03
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int NTAPS = ORDER + 1;

  logic step;
  logic [NTAPS:0][7:0] chain;

  assign chain[0] = 8'h00;

  gf_fir_flow flow_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_ready(out_ready),
    .in_ready (in_ready),
    .step     (step),
    .out_valid(out_valid)
  );

  // Cell k holds h[NTAPS-1-k]: the partial sum entering at cell k reaches the
  // output after NTAPS-1-k more steps, pairing h[j] with x[n-j].
  for (genvar k = 0; k < NTAPS; k++) begin : g_cell
    gf_fir_cell #(
      .COEF(H_PACK[8*(NTAPS-1-k) +: 8]),
      .POLY(POLY)
    ) cell_i (
      .clk     (clk),
      .rst     (rst),
      .step    (step),
      .x_bcast (in_data),
      .part_in (chain[k]),
      .part_out(chain[k+1])
    );
  end

  assign out_data = chain[NTAPS];
endmodule

// File: rtl/gf_fir_checker.sv
module gf_fir_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R9: first edge after reset leaves the output empty and cleared
  always_ff @(posedge clk) begin
    if (rst_q && !rst) begin
      p_reset_clear_r9: assert (!out_valid && out_data == 8'h00);
    end
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_accept_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> out_valid && !out_ready);
endmodule

bind gf_systolic_fir gf_fir_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/gf_systolic_fir_tb_top.sv
`timescale 1ns/1ps
module gf_systolic_fir_tb_top;
  localparam logic [95:0] HP = 96'h03_07_12_2C_4E_63_63_4E_2C_12_07_03;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b0;

  logic rdy7, rdy8, rdy11, ov7, ov8, ov11;
  logic [7:0] od7, od8, od11;

  int checks = 0;
  int errors = 0;

  logic [7:0] hist [12];
  logic       exp_valid;
  logic [7:0] exp7, exp8, exp11;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  gf_systolic_fir #(.ORDER(7), .H_PACK(HP)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy7), .in_data(in_data),
    .out_valid(ov7), .out_ready(out_ready), .out_data(od7));
  gf_systolic_fir #(.ORDER(8), .H_PACK(HP)) dut_o8_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy8), .in_data(in_data),
    .out_valid(ov8), .out_ready(out_ready), .out_data(od8));
  gf_systolic_fir #(.ORDER(11), .H_PACK(HP)) dut_o11_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy11), .in_data(in_data),
    .out_valid(ov11), .out_ready(out_ready), .out_data(od11));

  // Shift-and-add field product: add a when a bit of b is set, then multiply a by x.
  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, s;
    r = 8'h00;
    s = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ s;
      s = {s[6:0], 1'b0} ^ (s[7] ? 8'h1B : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_conv(input int taps);
    logic [7:0] y;
    y = 8'h00;
    for (int k = 0; k < taps; k++) y = y ^ ref_mul(HP[8*k +: 8], hist[k]);
    return y;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 12; k++) hist[k] = 8'h00;
    exp_valid = 1'b0;
    exp7 = 8'h00; exp8 = 8'h00; exp11 = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk("R9 valid", {7'd0, ov7}, 8'h00);
    chk("R9 data", od7, 8'h00);
    chk("R9 data order8", od8, 8'h00);
    chk("R9 data order11", od11, 8'h00);
    @(posedge clk); #1;
  endtask

  // One clock: drive, compare at the falling edge, advance the reference at the rising edge.
  task automatic cyc(input string tag, input logic iv, input logic [7:0] d, input logic ordy);
    logic rdy_exp, acc;
    in_valid = iv;
    in_data = d;
    out_ready = ordy;
    @(negedge clk);
    rdy_exp = !exp_valid || ordy;
    chk("R6 in_ready", {7'd0, rdy7}, {7'd0, rdy_exp});
    chk("R10 in_ready match", {6'd0, rdy8, rdy11}, {6'd0, rdy7, rdy7});
    chk("R4 R8 out_valid", {5'd0, ov7, ov8, ov11}, {5'd0, {3{exp_valid}}});
    if (exp_valid) begin
      chk(tag, od7, exp7);
      chk({tag, " R10 order8"}, od8, exp8);
      chk({tag, " R10 order11"}, od11, exp11);
    end
    acc = iv && rdy_exp;
    @(posedge clk);
    if (acc) begin
      for (int k = 11; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = d;
      exp7 = ref_conv(8);
      exp8 = ref_conv(9);
      exp11 = ref_conv(12);
      exp_valid = 1'b1;
    end else if (ordy) begin
      exp_valid = 1'b0;
    end
    #1;
  endtask

  function automatic logic [15:0] lf_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();

    // R2: impulse response reads the coefficients back in order
    cyc("R2 impulse", 1'b1, 8'h01, 1'b1);
    for (int i = 0; i < 14; i++) cyc("R2 impulse tail", 1'b1, 8'h00, 1'b1);
    cyc("R8 drain", 1'b0, 8'h00, 1'b1);
    cyc("R8 idle", 1'b0, 8'h00, 1'b1);

    // R1: every byte value through every tap, back to back
    for (int i = 0; i < 256; i++) cyc("R1 sweep", 1'b1, i[7:0], 1'b1);
    for (int i = 0; i < 256; i++) cyc("R1 sweep rev", 1'b1, 8'(255 - i), 1'b1);

    // R7: gaps in the input stream
    for (int i = 0; i < 300; i++) begin
      lf = lf_next(lf);
      cyc("R7 bubbles", lf[0] & lf[3], lf[15:8], 1'b1);
    end

    // R5 R6: back-pressure with offered samples that must not be taken
    for (int i = 0; i < 400; i++) begin
      lf = lf_next(lf);
      cyc("R5 R6 backpressure", lf[1] | lf[5], lf[11:4], lf[2]);
    end

    // R5: long stall with a value held
    cyc("R5 load", 1'b1, 8'hC3, 1'b0);
    for (int i = 0; i < 6; i++) cyc("R5 stall", 1'b1, 8'(i * 37), 1'b0);
    cyc("R5 release", 1'b0, 8'h00, 1'b1);

    // R3: reset mid-stream drops the history
    for (int i = 0; i < 5; i++) cyc("R3 prefill", 1'b1, 8'hFF, 1'b1);
    do_reset();
    cyc("R3 first", 1'b1, 8'h5A, 1'b1);
    cyc("R3 second", 1'b1, 8'hA5, 1'b1);
    chk("R3 after reset", od7, ref_mul(HP[7:0], 8'hA5) ^ ref_mul(HP[15:8], 8'h5A));
    for (int i = 0; i < 13; i++) cyc("R3 tail", 1'b1, 8'h00, 1'b1);
    cyc("R8 final", 1'b0, 8'h00, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule